// File: doc/BRIEF.md
# Ethernet Buffer-Descriptor Ring Controller

This block holds the descriptor table that a 10/100 Ethernet MAC shares between its transmit and receive paths, and it owns the interrupt status and mask state. One table of `NUM_BD` entries is split by a programmable boundary. Entries below the boundary form the transmit ring. Entries from the boundary up to the last entry form the receive ring. Each entry has two 32-bit words: a flags word that also carries the frame length, and a buffer pointer. The host fills both words through a simple word-addressed port.

The controller keeps one current index for each ring. It raises `tx_req` while the current transmit entry may be sent, and `rx_ok` while the current receive entry can take a frame. A separate data engine moves the frame and then reports completion with `tx_done`, or with `rx_done` together with the received length. On completion the controller rewrites the entry's flags, moves the ring index on according to that ring's wrap rule, and latches a status bit when the entry asks for an interrupt. The `irq` output is a level that follows the masked status.

Top module: `bd_ring_ctrl`

## Requirements
- R1: After reset the transmit index is 0, the boundary reads 0x40, the receive index equals the boundary, the control, status and mask registers read 0, every flags word reads 0, and `irq`, `tx_req` and `rx_ok` are low.
- R2: Table word address = entry*2 + w, where w=0 is the flags word and w=1 is the pointer word. The flags word has the length in bits 31:16, ready (transmit) or empty (receive) in bit 15, interrupt request in bit 14 and wrap in bit 13. A host write is read back unchanged on `tbl_rdata`.
- R3: `tx_req` is high exactly when the control transmit enable (bit 1) is set, the boundary is nonzero, the current transmit entry has bit 15 set and its length is greater than 4.
- R4: When `tx_done` arrives while `tx_req` is high, the transmit index becomes 0 if the entry's wrap bit was set or if index+1 is not below the boundary, and index+1 otherwise. A `tx_done` while `tx_req` is low changes neither the index, the table nor the status.
- R5: Transmit completion clears flags bits 15 and 8:0 and keeps every other bit. If bit 14 was set, it also sets status bit 0.
- R6: `rx_ok` is high exactly when the control receive enable (bit 0) is set, the boundary is below `NUM_BD`, and the current receive entry has bit 15 set.
- R7: When `rx_done` arrives while `rx_ok` is high, the receive index becomes the boundary if the entry's wrap bit was set or if the index was `NUM_BD`-1, and index+1 otherwise. An `rx_done` while `rx_ok` is low has no effect.
- R8: Receive completion writes `rx_len` into bits 31:16, clears bits 15 and 8:0 and keeps bits 14:9. If bit 14 was set, it also sets status bit 2.
- R9: A write to the status register clears each bit that is written as one and leaves the others alone. `irq` is high exactly when status AND mask is nonzero. A completion in the same cycle as a clear leaves its own bit set.
- R10: A control write that turns bit 0 from 0 to 1 reloads the receive index with the boundary. A control write that turns bit 1 from 0 to 1 reloads the transmit index with 0. A control write that rewrites a bit which is already set leaves that index unchanged.
- R11: Register select encoding: 0 control, 1 status, 2 mask, 3 boundary. `cfg_rdata` shows the selected register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Selected register value |
| tbl_we | input | 1 | Descriptor table write strobe |
| tbl_addr | input | 8 | Table word address (entry*2 + word) |
| tbl_wdata | input | 32 | Table write data |
| tbl_rdata | output | 32 | Table read data at `tbl_addr` |
| tx_req | output | 1 | Current transmit entry may be sent |
| tx_done | input | 1 | Transmit of current entry finished |
| tx_idx | output | 7 | Current transmit entry |
| rx_ok | output | 1 | Current receive entry can take a frame |
| rx_done | input | 1 | Frame stored in current receive entry |
| rx_len | input | 16 | Length of the stored frame |
| rx_idx | output | 7 | Current receive entry |
| irq | output | 1 | Interrupt level |

## Verification
The index-advance assertions assume that no control write lands in the same cycle as a completion, because a control reload takes priority over the advance. The bench never overlaps the two. The bench also keeps host table writes away from the entry that is completing in that cycle. Completion strobes that arrive while `tx_req` or `rx_ok` is low are driven on purpose, so the check covers that they have no effect. The receive sweep walks every entry from the boundary to the top of the table and through the wrap-around.

// File: rtl/bd_ring_ctrl.sv
module bd_ring_ctrl #(
  parameter int NUM_BD     = 128,
  parameter int BND_RST    = 64,
  parameter int MIN_TX_LEN = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [1:0]                    cfg_sel,
  input  logic [31:0]                   cfg_wdata,
  output logic [31:0]                   cfg_rdata,
  input  logic                          tbl_we,
  input  logic [$clog2(NUM_BD):0]       tbl_addr,
  input  logic [31:0]                   tbl_wdata,
  output logic [31:0]                   tbl_rdata,
  output logic                          tx_req,
  input  logic                          tx_done,
  output logic [$clog2(NUM_BD)-1:0]     tx_idx,
  output logic                          rx_ok,
  input  logic                          rx_done,
  input  logic [15:0]                   rx_len,
  output logic [$clog2(NUM_BD)-1:0]     rx_idx,
  output logic                          irq
);
  localparam int IW = $clog2(NUM_BD);
  localparam int BW = IW + 1;
  localparam int B_RDY  = 15;
  localparam int B_IRQ  = 14;
  localparam int B_WRAP = 13;
  localparam logic [31:0] DONE_CLR = 32'h0000_81FF;
  localparam logic [1:0] SEL_CTRL = 2'd0, SEL_STAT = 2'd1, SEL_MASK = 2'd2, SEL_BND = 2'd3;

  logic [31:0]   flags_mem [NUM_BD];
  logic [31:0]   ptr_mem   [NUM_BD];
  logic [1:0]    ctrl;
  logic [31:0]   stat, mask;
  logic [BW-1:0] bnd;

  logic [31:0] txf, rxf;
  logic        tx_fire, rx_fire, ctrl_wr, rx_rise, tx_rise;
  logic [IW:0]   tx_inc;
  logic [IW-1:0] tx_nxt, rx_nxt;
  logic [31:0]   stat_set, stat_clr;

  assign txf = flags_mem[tx_idx];
  assign rxf = flags_mem[rx_idx];

  assign tx_req = ctrl[1] && (bnd != '0) && txf[B_RDY] && (txf[31:16] > 16'(MIN_TX_LEN));
  assign rx_ok  = ctrl[0] && (bnd < BW'(NUM_BD)) && rxf[B_RDY];

  assign tx_fire = tx_done && tx_req;
  assign rx_fire = rx_done && rx_ok;

  assign ctrl_wr = cfg_we && (cfg_sel == SEL_CTRL);
  assign rx_rise = ctrl_wr && cfg_wdata[0] && !ctrl[0];
  assign tx_rise = ctrl_wr && cfg_wdata[1] && !ctrl[1];

  assign tx_inc = {1'b0, tx_idx} + 1'b1;
  assign tx_nxt = (txf[B_WRAP] || (tx_inc >= bnd)) ? '0 : tx_inc[IW-1:0];
  assign rx_nxt = (rxf[B_WRAP] || (rx_idx == IW'(NUM_BD - 1))) ? bnd[IW-1:0] : rx_idx + 1'b1;

  assign stat_set = {29'd0, rx_fire && rxf[B_IRQ], 1'b0, tx_fire && txf[B_IRQ]};
  assign stat_clr = (cfg_we && cfg_sel == SEL_STAT) ? cfg_wdata : '0;

  assign irq = |(stat & mask);

  assign tbl_rdata = tbl_addr[0] ? ptr_mem[tbl_addr[IW:1]] : flags_mem[tbl_addr[IW:1]];

  always_comb begin
    case (cfg_sel)
      SEL_CTRL: cfg_rdata = {30'd0, ctrl};
      SEL_STAT: cfg_rdata = stat;
      SEL_MASK: cfg_rdata = mask;
      default:  cfg_rdata = 32'(bnd);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BD; i++) flags_mem[i] <= '0;
    end else begin
      if (tbl_we && !tbl_addr[0]) flags_mem[tbl_addr[IW:1]] <= tbl_wdata;
      if (tx_fire) flags_mem[tx_idx] <= txf & ~DONE_CLR;
      if (rx_fire) flags_mem[rx_idx] <= {rx_len, rxf[15:0] & ~DONE_CLR[15:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (tbl_we && tbl_addr[0]) ptr_mem[tbl_addr[IW:1]] <= tbl_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      mask <= '0;
      bnd  <= BW'(BND_RST);
      stat <= '0;
    end else begin
      if (ctrl_wr) ctrl <= cfg_wdata[1:0];
      if (cfg_we && cfg_sel == SEL_MASK) mask <= cfg_wdata;
      if (cfg_we && cfg_sel == SEL_BND)  bnd  <= cfg_wdata[BW-1:0];
      stat <= (stat & ~stat_clr) | stat_set;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_idx <= '0;
      rx_idx <= IW'(BND_RST);
    end else begin
      if (tx_rise)      tx_idx <= '0;
      else if (tx_fire) tx_idx <= tx_nxt;
      if (rx_rise)      rx_idx <= bnd[IW-1:0];
      else if (rx_fire) rx_idx <= rx_nxt;
    end
  end

  p_tx_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fire && !ctrl_wr) |=> (tx_idx == '0 || tx_idx == IW'($past(tx_idx) + 1'b1)));

  p_rx_adv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire && !ctrl_wr) |=> (rx_idx == $past(bnd[IW-1:0]) || rx_idx == IW'($past(rx_idx) + 1'b1)));

  p_txb_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fire && txf[B_IRQ]) |=> stat[0]);

  p_rx_empty_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fire |=> !flags_mem[$past(rx_idx)][B_RDY]);

  p_w1c_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_STAT && (&cfg_wdata) && !tx_fire && !rx_fire) |=> (stat == '0 && !irq));

  p_rx_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rise |=> rx_idx == $past(bnd[IW-1:0]));
endmodule

// File: tb/bd_ring_ctrl_bench.sv
module bd_ring_ctrl_bench;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, tbl_we = 0, tx_done = 0, rx_done = 0;
  logic [1:0]  cfg_sel = 0;
  logic [31:0] cfg_wdata = 0, tbl_wdata = 0, cfg_rdata, tbl_rdata;
  logic [7:0]  tbl_addr = 0;
  logic [15:0] rx_len = 0;
  logic [6:0]  tx_idx, rx_idx;
  logic tx_req, rx_ok, irq;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  bd_ring_ctrl u_bd_ring_ctrl (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata), .tx_req(tx_req), .tx_done(tx_done),
    .tx_idx(tx_idx), .rx_ok(rx_ok), .rx_done(rx_done), .rx_len(rx_len), .rx_idx(rx_idx), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [1:0] s, input logic [31:0] d);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic wr_tbl(input int e, input int w, input logic [31:0] d);
    tbl_we = 1; tbl_addr = 8'(e * 2 + w); tbl_wdata = d;
    @(negedge clk); tbl_we = 0;
  endtask

  function automatic logic [31:0] rd_cfg(input logic [1:0] s);
    cfg_sel = s;
    return 32'(0);
  endfunction

  task automatic get_cfg(input logic [1:0] s, output logic [31:0] d);
    cfg_sel = s; #1 d = cfg_rdata;
  endtask

  task automatic get_tbl(input int e, input int w, output logic [31:0] d);
    tbl_addr = 8'(e * 2 + w); #1 d = tbl_rdata;
  endtask

  task automatic pulse_tx;
    tx_done = 1; @(negedge clk); tx_done = 0;
  endtask

  task automatic pulse_rx(input logic [15:0] l);
    rx_done = 1; rx_len = l; @(negedge clk); rx_done = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, v;
    int e, nxt, bnd;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 tx_idx", 32'(tx_idx), 0);
    chk("R1 rx_idx", 32'(rx_idx), 32'h40);
    chk("R1 irq/req/ok", {29'd0, irq, tx_req, rx_ok}, 0);
    get_cfg(2'd3, d); chk("R1 R11 boundary", d, 32'h40);
    get_cfg(2'd0, d); chk("R1 ctrl", d, 0);
    get_cfg(2'd1, d); chk("R1 status", d, 0);
    get_cfg(2'd2, d); chk("R1 mask", d, 0);
    for (int i = 0; i < 128; i += 17) begin get_tbl(i, 0, d); chk("R1 flags", d, 0); end

    // R2 readback of both words
    wr_tbl(5, 1, 32'hDEAD_BEEF); get_tbl(5, 1, d); chk("R2 pointer word", d, 32'hDEAD_BEEF);
    wr_tbl(5, 0, 32'h1234_5678); get_tbl(5, 0, d); chk("R2 flags word", d, 32'h1234_5678);
    get_tbl(5, 1, d); chk("R2 pointer kept", d, 32'hDEAD_BEEF);

    // R4 R5 transmit ring, boundary 4, two passes (second with wrap on entry 1)
    bnd = 4;
    wr_cfg(2'd3, 32'(bnd));
    wr_cfg(2'd0, 32'h2);
    e = 0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int k = 0; k < 6; k++) begin
        v = 32'h0040_0000 | 32'h8000 | 32'h4000 | 32'h1000 | 32'h01FF;
        if (pass == 1 && e == 1) v |= 32'h2000;
        wr_tbl(e, 0, v);
        chk("R3 tx_req ready", 32'(tx_req), 1);
        pulse_tx;
        nxt = v[13] ? 0 : ((e + 1 >= bnd) ? 0 : e + 1);
        chk("R4 tx index advance", 32'(tx_idx), 32'(nxt));
        get_tbl(e, 0, d); chk("R5 tx flags", d, v & ~32'h81FF);
        get_cfg(2'd1, d); chk("R5 status bit0", d, 32'h1);
        wr_cfg(2'd1, 32'h1);
        e = nxt;
      end
    end

    // R4 tx_done ignored while not ready
    wr_tbl(e, 0, 32'h0040_4000);
    chk("R3 tx_req not ready", 32'(tx_req), 0);
    pulse_tx;
    chk("R4 ignored index", 32'(tx_idx), 32'(e));
    get_tbl(e, 0, d); chk("R4 ignored flags", d, 32'h0040_4000);
    get_cfg(2'd1, d); chk("R4 ignored status", d, 0);

    // R10 transmit reload on rising edge only
    wr_tbl(0, 0, 32'h0040_8000); pulse_tx;
    chk("R4 step to 1", 32'(tx_idx), 1);
    wr_cfg(2'd0, 32'h2); chk("R10 no rise keeps tx", 32'(tx_idx), 1);
    wr_cfg(2'd0, 32'h0); wr_cfg(2'd0, 32'h2); chk("R10 tx reload", 32'(tx_idx), 0);

    // R3 eligibility sweep at entry 0
    for (int len = 3; len < 7; len++)
      for (int rdy = 0; rdy < 2; rdy++)
        for (int en = 0; en < 2; en++) begin
          wr_cfg(2'd0, 32'(en << 1));
          wr_tbl(0, 0, 32'(len << 16) | 32'(rdy << 15));
          chk("R3 tx_req sweep", 32'(tx_req), 32'((en == 1) && (rdy == 1) && (len > 4)));
        end
    wr_cfg(2'd3, 0);
    chk("R3 zero boundary", 32'(tx_req), 0);
    wr_cfg(2'd3, 32'(bnd));
    chk("R3 boundary restored", 32'(tx_req), 1);

    // R9 interrupt mask and write-one-to-clear
    wr_tbl(tx_idx, 0, 32'h0040_C000); pulse_tx;
    chk("R9 masked off", 32'(irq), 0);
    wr_cfg(2'd2, 32'h1); chk("R9 mask on", 32'(irq), 1);
    wr_cfg(2'd1, 32'h4); chk("R9 other bit no clear", 32'(irq), 1);
    get_cfg(2'd2, d); chk("R11 mask readback", d, 32'h1);
    wr_cfg(2'd1, 32'h1); chk("R9 cleared", 32'(irq), 0);
    wr_cfg(2'd0, 32'h0);

    // R6 R7 R8 receive ring walk through the top and wrap
    for (int i = bnd; i < 128; i++) wr_tbl(i, 0, 32'h0000_C1FF);
    wr_cfg(2'd2, 32'h4);
    wr_cfg(2'd0, 32'h1);
    chk("R10 rx reload", 32'(rx_idx), 32'(bnd));
    e = bnd;
    for (int k = 0; k < 132; k++) begin
      v = 32'h0000_C1FF;
      if (k == 130) v |= 32'h2000;
      wr_tbl(e, 0, v);
      chk("R6 rx_ok empty", 32'(rx_ok), 1);
      pulse_rx(16'(100 + k));
      nxt = (v[13] || e == 127) ? bnd : e + 1;
      chk("R7 rx index advance", 32'(rx_idx), 32'(nxt));
      get_tbl(e, 0, d); chk("R8 rx flags", d, (32'(100 + k) << 16) | (v & 32'h7E00));
      chk("R8 R9 irq rx", 32'(irq), 1);
      wr_cfg(2'd1, 32'h4);
      e = nxt;
    end

    // R8 no status without irq bit; R7 ignored when not empty
    wr_tbl(e, 0, 32'h0000_8000); pulse_rx(16'd60);
    get_cfg(2'd1, d); chk("R8 no irq bit", d, 0);
    e = e + 1;
    chk("R7 index", 32'(rx_idx), 32'(e));
    wr_tbl(e, 0, 32'h0000_4000);
    chk("R6 not empty", 32'(rx_ok), 0);
    pulse_rx(16'd77);
    chk("R7 ignored index", 32'(rx_idx), 32'(e));
    get_tbl(e, 0, d); chk("R7 ignored flags", d, 32'h0000_4000);

    // R10 receive rising edge, R6 boundary limit
    wr_cfg(2'd3, 32'h10);
    wr_cfg(2'd0, 32'h1); chk("R10 no rise keeps rx", 32'(rx_idx), 32'(e));
    wr_cfg(2'd0, 32'h0); wr_cfg(2'd0, 32'h1); chk("R10 rx reload new", 32'(rx_idx), 32'h10);
    wr_tbl(16, 0, 32'h0000_8000);
    chk("R6 rx_ok", 32'(rx_ok), 1);
    wr_cfg(2'd3, 32'h80);
    chk("R6 boundary too large", 32'(rx_ok), 0);

    // R9 completion wins over same-cycle clear
    wr_cfg(2'd3, 32'h10);
    wr_tbl(16, 0, 32'h0000_C000);
    cfg_we = 1; cfg_sel = 2'd1; cfg_wdata = 32'hFFFF_FFFF; rx_done = 1; rx_len = 16'd64;
    @(negedge clk); cfg_we = 0; rx_done = 0;
    get_cfg(2'd1, d); chk("R9 set beats clear", d, 32'h4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule